// File: doc/BRIEF.md
# Pad Ownership Multiplexer

This block decides, for each of eleven pads, whether the general-purpose I/O controller or one of the on-chip peripherals drives the pad and listens to it. The peripherals are an oscillator clock output, a two-wire I2C port, a four-wire SPI port, the two upper data lines of a quad SPI port, and a UART. Software controls ownership through a configuration register held inside the block. A hardware test-mode pin alone decides who owns pad 0.

For every pad, the block selects the output value and the output enable from the current owner. It returns the pad input to that owner and gives any peripheral that does not own its pads a fixed idle input. It also gives the I/O controller a per-pad claimed mask. The same mask blanks the controller's input capture for claimed pads, so the controller is isolated from a claimed pad in the same cycle that the ownership changes.

The pad map is fixed:

| Pad | Owner | Signal |
|-----|-------|--------|
| 0 | oscillator | clock output |
| 1 | I2C | SCL |
| 2 | I2C | SDA |
| 3 | SPI | chip select |
| 4 | SPI | clock |
| 5 | SPI | data 0 |
| 6 | SPI | data 1 |
| 7 | quad SPI | data 2 |
| 8 | quad SPI | data 3 |
| 9 | UART | TX |
| 10 | UART | RX |

Top module: `padOwnerMux`

## Requirements
- R1: After reset, cfgRdata reads 0x10, so only the SPI enable (bit 4) is set. With testMode low, gpioClaim reads 0x078, which claims pads 3 to 6.
- R2: While testMode is 1, pad 0 belongs to the oscillator: padOut[0] equals oscClk, padOe[0] is 1 and gpioClaim[0] is 1, whatever the configuration register holds. While testMode is 0, pad 0 belongs to the I/O controller.
- R3: Configuration bit 3 gives pad 1 (SCL) and pad 2 (SDA) to I2C as open-drain pads. padOut is 0 on both. padOe[1] equals i2cSclLow and padOe[2] equals i2cSdaLow.
- R4: Configuration bit 4 gives pads 3 to 6 to SPI. Pad 3 carries spiCsN and pad 4 carries spiSck, both with padOe at 1. Pads 5 and 6 carry spiDqOut[0] and spiDqOut[1], with output enables spiDqOe[0] and spiDqOe[1].
- R5: Configuration bit 5 gives pads 7 and 8 to quad SPI. They carry qspiDqOut[0] and qspiDqOut[1], with output enables qspiDqOe[0] and qspiDqOe[1].
- R6: Configuration bit 6 gives pads 9 and 10 to the UART. Pad 9 carries uartTx with padOe at 1. Pad 10 is an input, with padOe at 0 and padOut at 0.
- R7: On every pad that is not claimed, padOut equals gpioOut, padOe equals gpioOe and gpioIn equals padIn.
- R8: On every claimed pad, gpioOut and gpioOe have no effect on padOut or padOe, and gpioIn reads 0.
- R9: An owning peripheral receives its pad input. A peripheral that does not own its pads receives idle values: 1 on i2cSclIn, i2cSdaIn and uartRx, and 0 on spiDqIn and qspiDqIn.
- R10: Only configuration bits 3 to 6 are writable, and every other bit reads 0. A write with cfgWe changes cfgRdata and gpioClaim at the same clock edge, and neither changes before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | Hardware test-mode pin; gives pad 0 to the oscillator |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration register contents |
| oscClk | input | 1 | Oscillator clock to output on pad 0 |
| gpioOut | input | 11 | I/O controller output values |
| gpioOe | input | 11 | I/O controller output enables |
| gpioIn | output | 11 | Pad inputs to the I/O controller, 0 where claimed |
| gpioClaim | output | 11 | Per-pad mask of pads owned by a peripheral |
| i2cSclLow | input | 1 | I2C request to pull SCL low |
| i2cSdaLow | input | 1 | I2C request to pull SDA low |
| i2cSclIn | output | 1 | SCL level seen by I2C |
| i2cSdaIn | output | 1 | SDA level seen by I2C |
| spiCsN | input | 1 | SPI chip select |
| spiSck | input | 1 | SPI clock |
| spiDqOut | input | 2 | SPI data lines 1:0 output |
| spiDqOe | input | 2 | SPI data lines 1:0 output enable |
| spiDqIn | output | 2 | SPI data lines 1:0 input |
| qspiDqOut | input | 2 | Quad SPI data lines 3:2 output |
| qspiDqOe | input | 2 | Quad SPI data lines 3:2 output enable |
| qspiDqIn | output | 2 | Quad SPI data lines 3:2 input |
| uartTx | input | 1 | UART transmit data |
| uartRx | output | 1 | UART receive data |
| padIn | input | 11 | Pad input levels |
| padOut | output | 11 | Pad output values |
| padOe | output | 11 | Pad output enables |

## Verification
A wrong bit in the configuration register appears on gpioClaim and cfgRdata at the edge where the write lands. It also changes the padOe and padOut pattern of a whole pad group in the same cycle, so one sample after the edge exposes it. A routing fault inside a group shows only when the stimulus on that group differs between the GPIO and peripheral sources. For that reason every enable combination is swept with both test-mode levels under several unrelated input patterns, and each pad group is compared separately. Faults on the input side show as a nonzero gpioIn bit on a claimed pad, or as a missing idle value on a peripheral input.

// File: rtl/padOwnerPkg.sv
package padOwnerPkg;
  localparam int NUM_PADS  = 11;
  localparam int CFG_W     = 8;
  localparam int I2C_BIT   = 3;
  localparam int SPI_BIT   = 4;
  localparam int QSPI_BIT  = 5;
  localparam int UART_BIT  = 6;
  localparam int SPI_DQ_W  = 2;
  localparam int QSPI_DQ_W = 2;

  // Pad positions; each group is contiguous
  localparam int PAD_OSC = 0;
  localparam int PAD_SCL = 1;
  localparam int PAD_SDA = 2;
  localparam int PAD_CS  = 3;
  localparam int PAD_SCK = 4;
  localparam int PAD_SDQ = 5;
  localparam int PAD_QDQ = PAD_SDQ + SPI_DQ_W;
  localparam int PAD_TX  = PAD_QDQ + QSPI_DQ_W;
  localparam int PAD_RX  = PAD_TX + 1;

  localparam logic [CFG_W-1:0] CFG_MASK =
    (CFG_W'(1) << I2C_BIT) | (CFG_W'(1) << SPI_BIT) |
    (CFG_W'(1) << QSPI_BIT) | (CFG_W'(1) << UART_BIT);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(1) << SPI_BIT;

  // Ownership strobes passed from control to datapath
  typedef struct packed {
    logic osc;
    logic i2c;
    logic spi;
    logic qspi;
    logic uart;
  } ownT;
endpackage

// File: rtl/padOwnerCtrl.sv
module padOwnerCtrl
  import padOwnerPkg::*;
#(
  parameter int NPADS = NUM_PADS,
  parameter int CW    = CFG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          testMode,
  input  logic          cfgWe,
  input  logic [CW-1:0] cfgWdata,
  output logic [CW-1:0] cfgRdata,
  output ownT           own,
  output logic [NPADS-1:0] claim
);
  logic [CW-1:0] cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= CW'(CFG_RESET);
    else if (cfgWe) cfgReg <= cfgWdata & CW'(CFG_MASK);
  end

  assign cfgRdata = cfgReg;

  always_comb begin
    own.osc  = testMode;
    own.i2c  = cfgReg[I2C_BIT];
    own.spi  = cfgReg[SPI_BIT];
    own.qspi = cfgReg[QSPI_BIT];
    own.uart = cfgReg[UART_BIT];
  end

  always_comb begin
    claim = '0;
    claim[PAD_OSC] = own.osc;
    claim[PAD_SCL] = own.i2c;
    claim[PAD_SDA] = own.i2c;
    claim[PAD_CS]  = own.spi;
    claim[PAD_SCK] = own.spi;
    for (int k = 0; k < SPI_DQ_W; k++)  claim[PAD_SDQ + k] = own.spi;
    for (int k = 0; k < QSPI_DQ_W; k++) claim[PAD_QDQ + k] = own.qspi;
    claim[PAD_TX]  = own.uart;
    claim[PAD_RX]  = own.uart;
  end

  // Reserved bits never read back set
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~CW'(CFG_MASK)) == '0);
  // Claim on the SPI pads follows the written enable one edge later
  p_claim_tracks_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (claim[PAD_CS] == $past(cfgWdata[SPI_BIT])));
  // Without a write the register holds
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgRdata));
endmodule

// File: rtl/padOwnerRoute.sv
module padOwnerRoute
  import padOwnerPkg::*;
#(
  parameter int NPADS = NUM_PADS
) (
  input  logic             clk,
  input  logic             rstN,
  input  ownT              own,
  input  logic [NPADS-1:0] claim,
  input  logic             oscClk,
  input  logic [NPADS-1:0] gpioOut,
  input  logic [NPADS-1:0] gpioOe,
  output logic [NPADS-1:0] gpioIn,
  input  logic             i2cSclLow,
  input  logic             i2cSdaLow,
  output logic             i2cSclIn,
  output logic             i2cSdaIn,
  input  logic             spiCsN,
  input  logic             spiSck,
  input  logic [SPI_DQ_W-1:0]  spiDqOut,
  input  logic [SPI_DQ_W-1:0]  spiDqOe,
  output logic [SPI_DQ_W-1:0]  spiDqIn,
  input  logic [QSPI_DQ_W-1:0] qspiDqOut,
  input  logic [QSPI_DQ_W-1:0] qspiDqOe,
  output logic [QSPI_DQ_W-1:0] qspiDqIn,
  input  logic             uartTx,
  output logic             uartRx,
  input  logic [NPADS-1:0] padIn,
  output logic [NPADS-1:0] padOut,
  output logic [NPADS-1:0] padOe
);
  logic [NPADS-1:0] perOut;
  logic [NPADS-1:0] perOe;

  // Peripheral-side value for every pad, used only where claimed
  always_comb begin
    perOut = '0;
    perOe  = '0;
    perOut[PAD_OSC] = oscClk;
    perOe[PAD_OSC]  = 1'b1;
    perOe[PAD_SCL]  = i2cSclLow;   // open drain: enable only to pull low
    perOe[PAD_SDA]  = i2cSdaLow;
    perOut[PAD_CS]  = spiCsN;
    perOe[PAD_CS]   = 1'b1;
    perOut[PAD_SCK] = spiSck;
    perOe[PAD_SCK]  = 1'b1;
    for (int k = 0; k < SPI_DQ_W; k++) begin
      perOut[PAD_SDQ + k] = spiDqOut[k];
      perOe[PAD_SDQ + k]  = spiDqOe[k];
    end
    for (int k = 0; k < QSPI_DQ_W; k++) begin
      perOut[PAD_QDQ + k] = qspiDqOut[k];
      perOe[PAD_QDQ + k]  = qspiDqOe[k];
    end
    perOut[PAD_TX] = uartTx;
    perOe[PAD_TX]  = 1'b1;
  end

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    assign padOut[p] = claim[p] ? perOut[p] : gpioOut[p];
    assign padOe[p]  = claim[p] ? perOe[p]  : gpioOe[p];
    assign gpioIn[p] = padIn[p] & ~claim[p];

    // Claimed pads are invisible to the I/O controller
    p_isolate_r8: assert property (@(posedge clk) disable iff (!rstN)
      claim[p] |-> (gpioIn[p] == 1'b0));
  end

  assign i2cSclIn = own.i2c ? padIn[PAD_SCL] : 1'b1;
  assign i2cSdaIn = own.i2c ? padIn[PAD_SDA] : 1'b1;
  assign uartRx   = own.uart ? padIn[PAD_RX] : 1'b1;

  for (genvar k = 0; k < SPI_DQ_W; k++) begin : g_sdqIn
    assign spiDqIn[k] = own.spi & padIn[PAD_SDQ + k];
  end
  for (genvar k = 0; k < QSPI_DQ_W; k++) begin : g_qdqIn
    assign qspiDqIn[k] = own.qspi & padIn[PAD_QDQ + k];
  end

  p_osc_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    own.osc |-> (padOe[PAD_OSC] && padOut[PAD_OSC] == oscClk));
  p_i2c_open_drain_r3: assert property (@(posedge clk) disable iff (!rstN)
    own.i2c |-> (padOut[PAD_SCL] == 1'b0 && padOut[PAD_SDA] == 1'b0));
  p_uart_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    own.uart |-> (padOe[PAD_TX] && !padOe[PAD_RX]));
  p_i2c_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !own.i2c |-> (i2cSclIn && i2cSdaIn));
endmodule

// File: rtl/padOwnerMux.sv
module padOwnerMux
  import padOwnerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        testMode,
  input  logic        cfgWe,
  input  logic [7:0]  cfgWdata,
  output logic [7:0]  cfgRdata,
  input  logic        oscClk,
  input  logic [10:0] gpioOut,
  input  logic [10:0] gpioOe,
  output logic [10:0] gpioIn,
  output logic [10:0] gpioClaim,
  input  logic        i2cSclLow,
  input  logic        i2cSdaLow,
  output logic        i2cSclIn,
  output logic        i2cSdaIn,
  input  logic        spiCsN,
  input  logic        spiSck,
  input  logic [1:0]  spiDqOut,
  input  logic [1:0]  spiDqOe,
  output logic [1:0]  spiDqIn,
  input  logic [1:0]  qspiDqOut,
  input  logic [1:0]  qspiDqOe,
  output logic [1:0]  qspiDqIn,
  input  logic        uartTx,
  output logic        uartRx,
  input  logic [10:0] padIn,
  output logic [10:0] padOut,
  output logic [10:0] padOe
);
  ownT              own;
  logic [10:0]      claim;

  padOwnerCtrl #(.NPADS(NUM_PADS), .CW(CFG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .testMode (testMode),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .own      (own),
    .claim    (claim)
  );

  padOwnerRoute #(.NPADS(NUM_PADS)) u_route (
    .clk       (clk),
    .rstN      (rstN),
    .own       (own),
    .claim     (claim),
    .oscClk    (oscClk),
    .gpioOut   (gpioOut),
    .gpioOe    (gpioOe),
    .gpioIn    (gpioIn),
    .i2cSclLow (i2cSclLow),
    .i2cSdaLow (i2cSdaLow),
    .i2cSclIn  (i2cSclIn),
    .i2cSdaIn  (i2cSdaIn),
    .spiCsN    (spiCsN),
    .spiSck    (spiSck),
    .spiDqOut  (spiDqOut),
    .spiDqOe   (spiDqOe),
    .spiDqIn   (spiDqIn),
    .qspiDqOut (qspiDqOut),
    .qspiDqOe  (qspiDqOe),
    .qspiDqIn  (qspiDqIn),
    .uartTx    (uartTx),
    .uartRx    (uartRx),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe)
  );

  assign gpioClaim = claim;
endmodule

// File: tb/padOwnerMux_bench.sv
module padOwnerMux_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testMode = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        oscClk = 1'b0;
  logic [10:0] gpioOut = '0, gpioOe = '0, gpioIn, gpioClaim;
  logic        i2cSclLow = 1'b0, i2cSdaLow = 1'b0, i2cSclIn, i2cSdaIn;
  logic        spiCsN = 1'b0, spiSck = 1'b0;
  logic [1:0]  spiDqOut = '0, spiDqOe = '0, spiDqIn;
  logic [1:0]  qspiDqOut = '0, qspiDqOe = '0, qspiDqIn;
  logic        uartTx = 1'b0, uartRx;
  logic [10:0] padIn = '0, padOut, padOe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  padOwnerMux u_padOwnerMux (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Claim mask the requirements give for enables {uart,qspi,spi,i2c} and test mode
  function automatic logic [10:0] expClaim(input logic [3:0] en, input logic tm);
    return {en[3], en[3], en[2], en[2], en[1], en[1], en[1], en[1], en[0], en[0], tm};
  endfunction

  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic groupCheck(input string ownTag, input logic owned,
                            input logic [10:0] mask,
                            input logic [10:0] eOut, input logic [10:0] eOe);
    check(owned ? {ownTag, " padOut"} : "R7 padOut", 32'(padOut & mask), 32'(eOut & mask));
    check(owned ? {ownTag, " padOe"}  : "R7 padOe",  32'(padOe & mask),  32'(eOe & mask));
  endtask

  task automatic vectorCheck(input logic [3:0] en, input logic tm);
    logic [31:0] w1, w2;
    logic [10:0] c, perOut, perOe, eOut, eOe;
    w1 = nextRand();
    w2 = nextRand();
    gpioOut   = w1[10:0];
    gpioOe    = w1[21:11];
    padIn     = w2[10:0];
    oscClk    = w2[11];
    i2cSclLow = w2[12];
    i2cSdaLow = w2[13];
    spiCsN    = w2[14];
    spiSck    = w2[15];
    spiDqOut  = w2[17:16];
    spiDqOe   = w2[19:18];
    qspiDqOut = w2[21:20];
    qspiDqOe  = w2[23:22];
    uartTx    = w2[24];
    #1;
    c      = expClaim(en, tm);
    perOut = {1'b0, uartTx, qspiDqOut, spiDqOut, spiSck, spiCsN, 2'b00, oscClk};
    perOe  = {1'b0, 1'b1, qspiDqOe, spiDqOe, 2'b11, i2cSdaLow, i2cSclLow, 1'b1};
    eOut   = (c & perOut) | (~c & gpioOut);
    eOe    = (c & perOe)  | (~c & gpioOe);
    groupCheck("R2", tm,    11'h001, eOut, eOe);
    groupCheck("R3", en[0], 11'h006, eOut, eOe);
    groupCheck("R4", en[1], 11'h078, eOut, eOe);
    groupCheck("R5", en[2], 11'h180, eOut, eOe);
    groupCheck("R6", en[3], 11'h600, eOut, eOe);
    check("R8 gpioIn blocked on claimed pads", 32'(gpioIn & c), 32'h0);
    check("R7 gpioIn follows free pads", 32'(gpioIn & ~c), 32'(padIn & ~c));
    check("R10 gpioClaim", 32'(gpioClaim), 32'(c));
    check("R9 i2c inputs", 32'({i2cSclIn, i2cSdaIn}),
          32'(en[0] ? {padIn[1], padIn[2]} : 2'b11));
    check("R9 spi data in", 32'(spiDqIn), 32'(en[1] ? padIn[6:5] : 2'b00));
    check("R9 qspi data in", 32'(qspiDqIn), 32'(en[2] ? padIn[8:7] : 2'b00));
    check("R9 uart rx", 32'(uartRx), 32'(en[3] ? padIn[10] : 1'b1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [3:0] prevEn;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset cfgRdata", 32'(cfgRdata), 32'h10);
    check("R1 reset gpioClaim", 32'(gpioClaim), 32'h078);
    vectorCheck(4'b0010, 1'b0);
    prevEn = 4'b0010;

    for (int cfg = 0; cfg < 16; cfg++) begin
      @(negedge clk);
      testMode = 1'b0;
      cfgWe    = 1'b1;
      cfgWdata = {1'b1, cfg[3:0], 3'b101};   // reserved bits set on purpose
      #1;
      check("R10 no change before edge", 32'(gpioClaim), 32'(expClaim(prevEn, 1'b0)));
      @(negedge clk);
      cfgWe    = 1'b0;
      cfgWdata = 8'hFF;
      #1;
      check("R10 only bits 3..6 kept", 32'(cfgRdata), 32'({1'b0, cfg[3:0], 3'b000}));
      check("R10 claim after edge", 32'(gpioClaim), 32'(expClaim(cfg[3:0], 1'b0)));
      for (int tm = 0; tm < 2; tm++) begin
        testMode = tm[0];
        for (int pat = 0; pat < 4; pat++) vectorCheck(cfg[3:0], tm[0]);
      end
      prevEn = cfg[3:0];
    end

    // Writing zero releases every software pad (R1, R10)
    @(negedge clk);
    testMode = 1'b0;
    cfgWe    = 1'b1;
    cfgWdata = 8'h00;
    @(negedge clk);
    cfgWe = 1'b0;
    #1;
    check("R1 all released after zero write", 32'(gpioClaim), 32'h000);
    vectorCheck(4'b0000, 1'b0);
    finish();
  end
endmodule